// File: doc/BRIEF.md
# Single-Precision Operand Classifier and Flush-to-Zero Conditioner

This block sits in front of a single-precision floating-point datapath. It looks at two raw IEEE-754 binary32 source words together with a 4-bit operation code. For each operand it produces a conditioned copy that goes to the datapath, plus a 10-bit one-hot class mask. Operations that compute, compare or convert have subnormal operands replaced by a zero of the same sign. Sign-injection and classify operations get the raw bits unchanged. The class masks are always computed from the raw words, so a subnormal is reported as subnormal and not as zero.

On the output side, a registered result conditioner takes a result word and its five exception flags from the datapath. A subnormal result, or any result whose underflow flag is already raised, leaves the conditioner as a zero that keeps the result sign. A subnormal result also raises the underflow flag. The input path is purely combinational. The output conditioner adds one cycle of latency, and its valid bit follows the input valid.

Top module: `fp_opnd_cond`

## Requirements
- R1: Each operand's class mask has exactly one bit set. The bit order is: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signalling NaN, 9 quiet NaN.
- R2: An exponent field of all ones with a nonzero mantissa is classed as NaN: quiet (bit 9) when mantissa bit 22 is 1, signalling (bit 8) otherwise. An exponent of all ones with a zero mantissa is infinity (bit 0 or bit 7, chosen by sign).
- R3: An exponent of zero with a nonzero mantissa is classed as subnormal (bit 2 if negative, bit 5 if positive), whatever the operation code.
- R4: For operation codes 0 to 9 (add, subtract, multiply, min, max, equal, less-than, less-or-equal, float to signed integer, float to unsigned integer), an operand whose exponent is zero leaves with all bits 30:0 cleared and sign bit 31 unchanged.
- R5: For operation codes 0 to 9, an operand whose exponent is nonzero (normal, infinity or NaN) leaves unchanged.
- R6: For operation codes 10 to 15 (sign-inject 10, negated sign-inject 11, xor sign-inject 12, classify 13, unused 14 and 15), both operands leave bit-for-bit unchanged, including subnormals.
- R7: A valid result with exponent zero and nonzero mantissa appears one cycle later as a zero that keeps the input sign, with the underflow flag (flag bit 1) set and the other flag bits passed through.
- R8: A valid result whose incoming underflow flag (bit 1) is set appears one cycle later with bits 30:0 cleared, its sign kept and its flags unchanged.
- R9: Any other valid result, including a true zero, appears one cycle later with the word and flags unchanged. The output valid equals the input valid of the previous cycle.
- R10: While reset is asserted, the output valid, result word and flags are all zero.
- R11: In a cycle with no input valid, the result word and flags hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_kind | input | 4 | Operation code (see R4, R6) |
| src_a | input | 32 | Raw first operand |
| src_b | input | 32 | Raw second operand |
| opnd_a | output | 32 | Conditioned first operand |
| opnd_b | output | 32 | Conditioned second operand |
| cls_a | output | 10 | One-hot class mask of src_a |
| cls_b | output | 10 | One-hot class mask of src_b |
| res_vld_i | input | 1 | Datapath result valid |
| res_i | input | 32 | Datapath result word |
| res_flg_i | input | 5 | Result flags: 4 invalid, 3 divide-by-zero, 2 overflow, 1 underflow, 0 inexact |
| res_vld_o | output | 1 | Conditioned result valid |
| res_o | output | 32 | Conditioned result word |
| res_flg_o | output | 5 | Conditioned result flags |

## Verification
On every cycle the assertions check four things: each class mask is one-hot, a subnormal raw operand is always classed as subnormal, flushing ops never pass a nonzero mantissa under a zero exponent, and pass-through ops never change a bit. At the result side they also check that no subnormal ever leaves, that a flushed result carries underflow, that the sign survives, that valid has one cycle of latency, and that outputs hold when no valid arrives. Only the bench's scenarios show that each class bit lands at its exact position, that NaN quietness comes from mantissa bit 22, that the other flag bits pass through untouched, and the reset values.

// File: rtl/fpcls_pkg.sv
package fpcls_pkg;
  localparam int CLS_W = 10;
  localparam int FLG_W = 5;

  // class mask bit positions
  localparam int CLS_NINF  = 0;
  localparam int CLS_NNORM = 1;
  localparam int CLS_NSUB  = 2;
  localparam int CLS_NZERO = 3;
  localparam int CLS_PZERO = 4;
  localparam int CLS_PSUB  = 5;
  localparam int CLS_PNORM = 6;
  localparam int CLS_PINF  = 7;
  localparam int CLS_SNAN  = 8;
  localparam int CLS_QNAN  = 9;

  // flag bit positions
  localparam int FLG_UF = 1;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,  OP_SUB   = 4'd1,  OP_MUL   = 4'd2,  OP_MIN   = 4'd3,
    OP_MAX   = 4'd4,  OP_CEQ   = 4'd5,  OP_CLT   = 4'd6,  OP_CLE   = 4'd7,
    OP_F2SI  = 4'd8,  OP_F2UI  = 4'd9,  OP_SINJ  = 4'd10, OP_SINJN = 4'd11,
    OP_SINJX = 4'd12, OP_CLASS = 4'd13, OP_RSV0  = 4'd14, OP_RSV1  = 4'd15
  } op_kind_e;

  // last operation code that takes flushed operands
  localparam op_kind_e OP_LAST_FLUSH = OP_F2UI;
endpackage

// File: rtl/fp_classify.sv
module fp_classify
  import fpcls_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word_i,
  output logic [CLS_W-1:0]     cls_o
);
  localparam int WORD_W = EXP_W + MAN_W + 1;

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic             ex_zero, ex_ones, mn_zero;

  always_comb begin
    sgn     = word_i[WORD_W-1];
    ex      = word_i[WORD_W-2 -: EXP_W];
    mn      = word_i[MAN_W-1:0];
    ex_zero = (ex == '0);
    ex_ones = (ex == '1);
    mn_zero = (mn == '0);
    cls_o   = '0;
    if (ex_ones) begin
      if (mn_zero)             cls_o[sgn ? CLS_NINF : CLS_PINF] = 1'b1;
      else if (mn[MAN_W-1])    cls_o[CLS_QNAN] = 1'b1;
      else                     cls_o[CLS_SNAN] = 1'b1;
    end else if (ex_zero) begin
      if (mn_zero)             cls_o[sgn ? CLS_NZERO : CLS_PZERO] = 1'b1;
      else                     cls_o[sgn ? CLS_NSUB : CLS_PSUB] = 1'b1;
    end else begin
      cls_o[sgn ? CLS_NNORM : CLS_PNORM] = 1'b1;
    end
  end
endmodule

// File: rtl/fp_in_flush.sv
module fp_in_flush
  import fpcls_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [3:0]           op_kind_i,
  input  logic [EXP_W+MAN_W:0] word_i,
  output logic [EXP_W+MAN_W:0] word_o
);
  localparam int WORD_W = EXP_W + MAN_W + 1;

  logic flush_op;
  logic ex_zero;

  always_comb begin
    flush_op = (op_kind_i <= OP_LAST_FLUSH);
    ex_zero  = (word_i[WORD_W-2 -: EXP_W] == '0);
    word_o   = word_i;
    if (flush_op && ex_zero) word_o[MAN_W-1:0] = '0;
  end
endmodule

// File: rtl/fp_res_cond.sv
module fp_res_cond
  import fpcls_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld_i,
  input  logic [EXP_W+MAN_W:0] res_i,
  input  logic [FLG_W-1:0]     flg_i,
  output logic                 vld_o,
  output logic [EXP_W+MAN_W:0] res_o,
  output logic [FLG_W-1:0]     flg_o
);
  localparam int WORD_W = EXP_W + MAN_W + 1;

  logic              subn_in, zap;
  logic [WORD_W-1:0] res_d;
  logic [FLG_W-1:0]  flg_d;
  logic              armed_q;

  // next-state
  always_comb begin
    subn_in = (res_i[WORD_W-2 -: EXP_W] == '0) && (res_i[MAN_W-1:0] != '0);
    zap     = subn_in || flg_i[FLG_UF];
    res_d   = res_i;
    flg_d   = flg_i;
    if (zap) res_d[WORD_W-2:0] = '0;
    if (subn_in) flg_d[FLG_UF] = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o   <= 1'b0;
      res_o   <= '0;
      flg_o   <= '0;
      armed_q <= 1'b0;
    end else begin
      vld_o   <= vld_i;
      armed_q <= 1'b1;
      if (vld_i) begin
        res_o <= res_d;
        flg_o <= flg_d;
      end
    end
  end

  p_no_subn_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_o[WORD_W-2 -: EXP_W] == '0) |-> (res_o[MAN_W-1:0] == '0));

  p_uf_on_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && res_i[WORD_W-2 -: EXP_W] == '0 && res_i[MAN_W-1:0] != '0)
    |=> (flg_o[FLG_UF] && res_o[WORD_W-2:0] == '0));

  p_sign_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (res_o[WORD_W-1] == $past(res_i[WORD_W-1])));

  p_vld_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (vld_o == $past(vld_i)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ($stable(res_o) && $stable(flg_o)));
endmodule

// File: rtl/fp_opnd_cond.sv
module fp_opnd_cond
  import fpcls_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = EXP_W + MAN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_kind,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  output logic [WORD_W-1:0] opnd_a,
  output logic [WORD_W-1:0] opnd_b,
  output logic [CLS_W-1:0]  cls_a,
  output logic [CLS_W-1:0]  cls_b,
  input  logic              res_vld_i,
  input  logic [WORD_W-1:0] res_i,
  input  logic [FLG_W-1:0]  res_flg_i,
  output logic              res_vld_o,
  output logic [WORD_W-1:0] res_o,
  output logic [FLG_W-1:0]  res_flg_o
);
  localparam int N_OPND = 2;

  logic [WORD_W-1:0] raw  [N_OPND];
  logic [WORD_W-1:0] cond [N_OPND];
  logic [CLS_W-1:0]  cls  [N_OPND];

  assign raw[0] = src_a;
  assign raw[1] = src_b;
  assign opnd_a = cond[0];
  assign opnd_b = cond[1];
  assign cls_a  = cls[0];
  assign cls_b  = cls[1];

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    fp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .word_i (raw[g]),
      .cls_o  (cls[g])
    );
    fp_in_flush #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_flush (
      .op_kind_i (op_kind),
      .word_i    (raw[g]),
      .word_o    (cond[g])
    );

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cls[g]) == 1);

    p_subn_cls_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[g][WORD_W-2 -: EXP_W] == '0 && raw[g][MAN_W-1:0] != '0)
      |-> (cls[g][CLS_NSUB] || cls[g][CLS_PSUB]));

    p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind <= 4'd9 && raw[g][WORD_W-2 -: EXP_W] == '0)
      |-> (cond[g] == {raw[g][WORD_W-1], {(WORD_W-1){1'b0}}}));

    p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind >= 4'd10) |-> (cond[g] == raw[g]));
  end

  fp_res_cond #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (res_vld_i),
    .res_i (res_i),
    .flg_i (res_flg_i),
    .vld_o (res_vld_o),
    .res_o (res_o),
    .flg_o (res_flg_o)
  );
endmodule

// File: tb/fp_opnd_cond_bench.sv
`timescale 1ns/1ps
module fp_opnd_cond_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_kind;
  logic [31:0] src_a, src_b, opnd_a, opnd_b, res_i, res_o;
  logic [9:0]  cls_a, cls_b;
  logic        res_vld_i, res_vld_o;
  logic [4:0]  res_flg_i, res_flg_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fp_opnd_cond u_fp_opnd_cond (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .src_a(src_a), .src_b(src_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .cls_a(cls_a), .cls_b(cls_b),
    .res_vld_i(res_vld_i), .res_i(res_i), .res_flg_i(res_flg_i),
    .res_vld_o(res_vld_o), .res_o(res_o), .res_flg_o(res_flg_o)
  );

  // expected class mask, from R1/R2/R3
  function automatic logic [9:0] exp_cls(input logic [31:0] w);
    logic [9:0] c = '0;
    if (w[30:23] == 8'hFF) begin
      if (w[22:0] == 0) c[w[31] ? 0 : 7] = 1'b1;
      else if (w[22])   c[9] = 1'b1;
      else              c[8] = 1'b1;
    end else if (w[30:23] == 8'h00) begin
      if (w[22:0] == 0) c[w[31] ? 3 : 4] = 1'b1;
      else              c[w[31] ? 2 : 5] = 1'b1;
    end else            c[w[31] ? 1 : 6] = 1'b1;
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic drive_ops(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_kind = op; src_a = a; src_b = b;
    #1;
  endtask

  task automatic push_res(input logic [31:0] r, input logic [4:0] f);
    @(negedge clk);
    res_vld_i = 1'b1; res_i = r; res_flg_i = f;
    @(negedge clk);
    res_vld_i = 1'b0; res_i = 32'h1234_5678; res_flg_i = 5'h1F;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; res_vld_i = 1'b1; res_i = 32'h3F80_0000; res_flg_i = 5'h1F;
    op_kind = 4'd0; src_a = 0; src_b = 0;
    repeat (3) @(negedge clk);
    chk("R10 vld", {31'd0, res_vld_o}, 32'd0);
    chk("R10 res", res_o, 32'd0);
    chk("R10 flg", {27'd0, res_flg_o}, 32'd0);
    res_vld_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_classes();
    logic [31:0] v [10] = '{32'hFF80_0000, 32'hC000_0000, 32'h8000_0001, 32'h8000_0000,
                            32'h0000_0000, 32'h007F_FFFF, 32'h3F80_0000, 32'h7F80_0000,
                            32'h7F80_0001, 32'hFFC0_0000};
    for (int i = 0; i < 10; i++) begin
      drive_ops(4'd13, v[i], v[9-i]);
      chk($sformatf("R1 cls_a bit%0d", i), {22'd0, cls_a}, {22'd0, 10'd1 << i});
      chk("R2 R3 cls_b", {22'd0, cls_b}, {22'd0, exp_cls(v[9-i])});
    end
    // R2: signalling NaN with top mantissa bit clear, other bits set
    drive_ops(4'd0, 32'h7FBF_FFFF, 32'hFFC0_0001);
    chk("R2 snan", {22'd0, cls_a}, {22'd0, 10'h100});
    chk("R2 qnan", {22'd0, cls_b}, {22'd0, 10'h200});
    // R3: subnormal stays classed as subnormal under a flushing op
    drive_ops(4'd2, 32'h8040_0000, 32'h0000_0010);
    chk("R3 flushop cls_a", {22'd0, cls_a}, {22'd0, 10'h004});
    chk("R3 flushop cls_b", {22'd0, cls_b}, {22'd0, 10'h020});
  endtask

  task automatic t_flush();
    for (int op = 0; op < 10; op++) begin
      drive_ops(op[3:0], 32'h8012_3456, 32'h0000_0001);
      chk($sformatf("R4 op%0d a", op), opnd_a, 32'h8000_0000);
      chk($sformatf("R4 op%0d b", op), opnd_b, 32'h0000_0000);
    end
    drive_ops(4'd0, 32'h4049_0FDB, 32'hFF80_0000);
    chk("R5 normal", opnd_a, 32'h4049_0FDB);
    chk("R5 inf", opnd_b, 32'hFF80_0000);
    drive_ops(4'd9, 32'h7F80_0005, 32'h0080_0000);
    chk("R5 nan", opnd_a, 32'h7F80_0005);
    chk("R5 min normal", opnd_b, 32'h0080_0000);
  endtask

  task automatic t_pass();
    for (int op = 10; op < 16; op++) begin
      drive_ops(op[3:0], 32'h8012_3456, 32'h0000_0001);
      chk($sformatf("R6 op%0d a", op), opnd_a, 32'h8012_3456);
      chk($sformatf("R6 op%0d b", op), opnd_b, 32'h0000_0001);
    end
  endtask

  task automatic t_result();
    push_res(32'h8000_0ABC, 5'b00001);
    chk("R7 res neg subn", res_o, 32'h8000_0000);
    chk("R7 flg", {27'd0, res_flg_o}, {27'd0, 5'b00011});
    chk("R9 vld", {31'd0, res_vld_o}, 32'd1);
    push_res(32'h0040_0000, 5'b10000);
    chk("R7 res pos subn", res_o, 32'h0000_0000);
    chk("R7 flg pass", {27'd0, res_flg_o}, {27'd0, 5'b10010});
    push_res(32'hBF80_0000, 5'b00011);
    chk("R8 uf in", res_o, 32'h8000_0000);
    chk("R8 flg", {27'd0, res_flg_o}, {27'd0, 5'b00011});
    push_res(32'h4120_0000, 5'b00101);
    chk("R9 normal", res_o, 32'h4120_0000);
    chk("R9 flg", {27'd0, res_flg_o}, {27'd0, 5'b00101});
    push_res(32'h8000_0000, 5'b00000);
    chk("R9 true zero", res_o, 32'h8000_0000);
    chk("R9 zero flg", {27'd0, res_flg_o}, 32'd0);
    // R11: push_res left valid low with different data; one more cycle
    @(negedge clk);
    chk("R9 vld low", {31'd0, res_vld_o}, 32'd0);
    chk("R11 hold res", res_o, 32'h8000_0000);
    chk("R11 hold flg", {27'd0, res_flg_o}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_classes();
    t_flush();
    t_pass();
    t_result();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule